// File: doc/BRIEF.md
# Power-Good Latch and Power-Down Sequencer

This block sits in front of a clock generator's oscillator and PLLs and owns a single shared control pin. Right after power-up the pin is an active-low power-good indication: the first time it is seen low, the two CPU frequency-select inputs are captured into a frozen rate code. The code is never re-taken afterwards except in test mode.

Once the rate is captured, the same pin becomes an active-high power-down request. A request is honoured only after two consecutive synchronized samples see it high. The block first gates every clock output to its parked level. It then drops the PLL enable, and only after that drops the oscillator enable. Releasing the request turns the oscillator on again and waits a parameterised settling count before enabling the PLL. Outputs are ungated a fixed number of cycles after the PLL reports lock.

A test-entry input, qualified by a mode input, requests either high-impedance outputs or reference-divided outputs. All inputs are synchronized into the control clock domain. The control clock is assumed to be a free-running source that is independent of the oscillator being switched.

Top module: `pgseq_top`

## Requirements
- R1: After reset `rate_valid` is 0. It becomes 1 three clock edges after `pg_pd_pin` is driven low, and it then stays 1 until the next reset.
- R2: The captured `cpu_rate` encodes {`fsel_c`,`fsel_b`} as follows: 10 gives 0 (100 MHz), 00 gives 1 (133 MHz), 01 gives 2 (166 MHz), 11 gives 3 (200 MHz).
- R3: Outside test mode, once `rate_valid` is 1, later changes on the select inputs and on `pg_pd_pin` (including full power-down and power-up cycles) never change `cpu_rate`.
- R4: While `test_entry` is 1, `cpu_rate` is re-captured from the select inputs on every cycle in which the synchronized pin is low, and power-down requests are ignored (`clk_out_en` stays 1).
- R5: `out_hiz` equals `test_entry & ~test_pick` and `out_refdiv` equals `test_entry & test_pick`, each appearing three clock edges after the inputs change.
- R6: A power-down request is accepted only when the synchronized pin is high on two consecutive edges. `clk_out_en` falls four edges after the pin rises, and a high pulse lasting one clock is ignored.
- R7: Shutdown order: `clk_out_en` falls first. `pll_en` falls PARK_CYCLES edges later, and `osc_en` falls another PARK_CYCLES edges after that.
- R8: When the pin is released from a completed power-down, `osc_en` rises three edges later. `pll_en` stays 0 for OSC_SETTLE more edges and then rises.
- R9: `clk_out_en` rises only while the synchronized `pll_lock` is 1 and `rate_valid` is 1, EN_DELAY edges after both hold. Before the first power-good event the outputs stay gated.
- R10: Reset state: `osc_en`=1, `pll_en`=0, `clk_out_en`=0, `rate_valid`=0, `cpu_rate`=0, `out_hiz`=0, `out_refdiv`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running control clock |
| rst | input | 1 | Synchronous active-high reset |
| pg_pd_pin | input | 1 | Shared pin: active-low power-good first, then active-high power-down |
| fsel_c | input | 1 | Frequency select, upper bit |
| fsel_b | input | 1 | Frequency select, lower bit |
| test_entry | input | 1 | 1 selects test mode |
| test_pick | input | 1 | In test mode: 0 high-impedance, 1 reference divided |
| pll_lock | input | 1 | Lock indication from the PLLs |
| cpu_rate | output | 2 | Latched CPU rate code (read-only status) |
| rate_valid | output | 1 | Rate code has been captured |
| osc_en | output | 1 | Crystal oscillator enable |
| pll_en | output | 1 | PLL enable |
| clk_out_en | output | 1 | Clock output gate, 0 parks outputs |
| out_hiz | output | 1 | Test request: outputs high impedance |
| out_refdiv | output | 1 | Test request: outputs carry reference divided |

## Verification
The hardest situation to reach is a full power-down and power-up cycle after the rate code is frozen, with the select inputs changed during the cycle. This combination proves that the second low level on the pin is not mistaken for a fresh power-good event. The stimulus reaches it by locking a rate, changing both select inputs, and driving a qualified request that runs to the oscillator-off state. It then releases the pin and waits for the outputs to return, with a small PLL model in the bench that asserts lock a few cycles after `pll_en`. Single-cycle pin glitches in the running state and requests issued inside test mode are also driven to cover the qualification and masking paths.

// File: rtl/pgseq_pkg.sv
package pgseq_pkg;

  typedef enum logic [2:0] {
    ST_OSC_SETTLE = 3'd0,
    ST_PLL_WAIT   = 3'd1,
    ST_OUT_WAIT   = 3'd2,
    ST_RUN        = 3'd3,
    ST_PARK       = 3'd4,
    ST_PLL_OFF    = 3'd5,
    ST_OFF        = 3'd6
  } seq_state_t;

  typedef enum logic [1:0] {
    CPU_100 = 2'd0,
    CPU_133 = 2'd1,
    CPU_166 = 2'd2,
    CPU_200 = 2'd3
  } cpu_rate_t;

  // select pair {upper, lower} to rate code
  function automatic cpu_rate_t decode_rate(input logic sel_c, input logic sel_b);
    case ({sel_c, sel_b})
      2'b10:   decode_rate = CPU_100;
      2'b00:   decode_rate = CPU_133;
      2'b01:   decode_rate = CPU_166;
      default: decode_rate = CPU_200;
    endcase
  endfunction

endpackage

// File: rtl/pgseq_sync.sv
module pgseq_sync #(
  parameter int unsigned        WIDTH   = 1,
  parameter int unsigned        STAGES  = 2,
  parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= RST_VAL;
    else     stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[i] <= RST_VAL;
      else     stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/pgseq_rate_latch.sv
module pgseq_rate_latch
  import pgseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       pin_s,
  input  logic       sel_c_s,
  input  logic       sel_b_s,
  input  logic       test_s,
  output logic [1:0] rate_q,
  output logic       valid_q
);

  logic      capture;
  cpu_rate_t rate_nxt;

  // low pin is power-good; one shot unless test mode reopens it
  assign capture  = !pin_s && (!valid_q || test_s);
  assign rate_nxt = decode_rate(sel_c_s, sel_b_s);

  always_ff @(posedge clk) begin
    if (rst) begin
      rate_q  <= 2'd0;
      valid_q <= 1'b0;
    end else if (capture) begin
      rate_q  <= rate_nxt;
      valid_q <= 1'b1;
    end
  end

  AST_VALID_STICKY: assert property (@(posedge clk) disable iff (rst)
    valid_q |=> valid_q); // R1

  AST_RATE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (valid_q && !test_s) |=> $stable(rate_q)); // R3

  AST_CAPTURE_ON_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(valid_q) |-> !$past(pin_s)); // R1

endmodule

// File: rtl/pgseq_seq.sv
module pgseq_seq
  import pgseq_pkg::*;
#(
  parameter int unsigned OSC_SETTLE  = 1024,
  parameter int unsigned PARK_CYCLES = 4,
  parameter int unsigned EN_DELAY    = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_s,
  input  logic valid,
  input  logic test_s,
  input  logic lock_s,
  output logic osc_en_q,
  output logic pll_en_q,
  output logic out_en_q
);

  localparam int unsigned MAX_A  = (OSC_SETTLE > PARK_CYCLES) ? OSC_SETTLE : PARK_CYCLES;
  localparam int unsigned MAX_C  = (MAX_A > EN_DELAY) ? MAX_A : EN_DELAY;
  localparam int unsigned CW     = $clog2(MAX_C + 1);
  localparam logic [CW-1:0] SETTLE_LAST = CW'(OSC_SETTLE - 1);
  localparam logic [CW-1:0] PARK_LAST   = CW'(PARK_CYCLES - 1);
  localparam logic [CW-1:0] EN_LAST     = CW'(EN_DELAY - 1);

  seq_state_t    state_q, state_nxt;
  logic [CW-1:0] cnt_q, cnt_nxt;
  logic          pin_d;
  logic          pd_qual;

  // second sample of the request, for two-edge qualification
  always_ff @(posedge clk) begin
    if (rst) pin_d <= 1'b1;
    else     pin_d <= pin_s;
  end

  assign pd_qual = valid && !test_s && pin_s && pin_d;

  always_comb begin
    state_nxt = state_q;
    cnt_nxt   = cnt_q;
    case (state_q)
      ST_OSC_SETTLE: begin
        if (cnt_q == SETTLE_LAST) begin
          state_nxt = ST_PLL_WAIT;
          cnt_nxt   = '0;
        end else begin
          cnt_nxt = cnt_q + 1'b1;
        end
      end
      ST_PLL_WAIT: begin
        if (lock_s) begin
          state_nxt = ST_OUT_WAIT;
          cnt_nxt   = '0;
        end
      end
      ST_OUT_WAIT: begin
        if (valid && lock_s) begin
          if (cnt_q == EN_LAST) begin
            state_nxt = ST_RUN;
            cnt_nxt   = '0;
          end else begin
            cnt_nxt = cnt_q + 1'b1;
          end
        end
      end
      ST_RUN: ;
      ST_PARK: begin
        if (cnt_q == PARK_LAST) begin
          state_nxt = ST_PLL_OFF;
          cnt_nxt   = '0;
        end else begin
          cnt_nxt = cnt_q + 1'b1;
        end
      end
      ST_PLL_OFF: begin
        if (cnt_q == PARK_LAST) begin
          state_nxt = ST_OFF;
          cnt_nxt   = '0;
        end else begin
          cnt_nxt = cnt_q + 1'b1;
        end
      end
      ST_OFF: begin
        if (!pin_s) begin
          state_nxt = ST_OSC_SETTLE;
          cnt_nxt   = '0;
        end
      end
      default: begin
        state_nxt = ST_OSC_SETTLE;
        cnt_nxt   = '0;
      end
    endcase
    // request preempts any active state
    if (pd_qual && (state_q == ST_OSC_SETTLE || state_q == ST_PLL_WAIT ||
                    state_q == ST_OUT_WAIT   || state_q == ST_RUN)) begin
      state_nxt = ST_PARK;
      cnt_nxt   = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_OSC_SETTLE;
      cnt_q    <= '0;
      osc_en_q <= 1'b1;
      pll_en_q <= 1'b0;
      out_en_q <= 1'b0;
    end else begin
      state_q  <= state_nxt;
      cnt_q    <= cnt_nxt;
      osc_en_q <= (state_nxt != ST_OFF);
      pll_en_q <= (state_nxt == ST_PLL_WAIT) || (state_nxt == ST_OUT_WAIT) ||
                  (state_nxt == ST_RUN)      || (state_nxt == ST_PARK);
      out_en_q <= (state_nxt == ST_RUN);
    end
  end

  AST_PD_TWO_SAMPLES: assert property (@(posedge clk) disable iff (rst)
    $fell(out_en_q) |-> ($past(pin_s) && $past(pin_d) && !$past(test_s))); // R6

  AST_PLL_OFF_AFTER_PARK: assert property (@(posedge clk) disable iff (rst)
    $fell(pll_en_q) |-> (!out_en_q && !$past(out_en_q))); // R7

  AST_OSC_OFF_LAST: assert property (@(posedge clk) disable iff (rst)
    $fell(osc_en_q) |-> (!pll_en_q && !$past(pll_en_q) && !out_en_q)); // R7

  AST_OUT_NEEDS_LOCK: assert property (@(posedge clk) disable iff (rst)
    $rose(out_en_q) |-> ($past(lock_s) && $past(valid))); // R9

  AST_PLL_NEEDS_OSC: assert property (@(posedge clk) disable iff (rst)
    $rose(pll_en_q) |-> (osc_en_q && $past(osc_en_q))); // R8

endmodule

// File: rtl/pgseq_top.sv
module pgseq_top
  import pgseq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned OSC_SETTLE  = 1024,
  parameter int unsigned PARK_CYCLES = 4,
  parameter int unsigned EN_DELAY    = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pg_pd_pin,
  input  logic       fsel_c,
  input  logic       fsel_b,
  input  logic       test_entry,
  input  logic       test_pick,
  input  logic       pll_lock,
  output logic [1:0] cpu_rate,
  output logic       rate_valid,
  output logic       osc_en,
  output logic       pll_en,
  output logic       clk_out_en,
  output logic       out_hiz,
  output logic       out_refdiv
);

  localparam int unsigned NSYNC = 6;
  // bit order: pin, sel_c, sel_b, test_entry, test_pick, lock
  localparam logic [NSYNC-1:0] SYNC_RST = 6'b100000;

  logic [NSYNC-1:0] raw_in, syn;
  logic pin_s, sel_c_s, sel_b_s, tsel_s, tpick_s, lock_s;

  assign raw_in = {pg_pd_pin, fsel_c, fsel_b, test_entry, test_pick, pll_lock};

  pgseq_sync #(
    .WIDTH  (NSYNC),
    .STAGES (SYNC_STAGES),
    .RST_VAL(SYNC_RST)
  ) u_sync (
    .clk(clk),
    .rst(rst),
    .d  (raw_in),
    .q  (syn)
  );

  assign {pin_s, sel_c_s, sel_b_s, tsel_s, tpick_s, lock_s} = syn;

  pgseq_rate_latch u_latch (
    .clk    (clk),
    .rst    (rst),
    .pin_s  (pin_s),
    .sel_c_s(sel_c_s),
    .sel_b_s(sel_b_s),
    .test_s (tsel_s),
    .rate_q (cpu_rate),
    .valid_q(rate_valid)
  );

  pgseq_seq #(
    .OSC_SETTLE (OSC_SETTLE),
    .PARK_CYCLES(PARK_CYCLES),
    .EN_DELAY   (EN_DELAY)
  ) u_seq (
    .clk     (clk),
    .rst     (rst),
    .pin_s   (pin_s),
    .valid   (rate_valid),
    .test_s  (tsel_s),
    .lock_s  (lock_s),
    .osc_en_q(osc_en),
    .pll_en_q(pll_en),
    .out_en_q(clk_out_en)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_hiz    <= 1'b0;
      out_refdiv <= 1'b0;
    end else begin
      out_hiz    <= tsel_s & ~tpick_s;
      out_refdiv <= tsel_s &  tpick_s;
    end
  end

  AST_TEST_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(out_hiz && out_refdiv)); // R5

endmodule

// File: tb/pgseq_tb.sv
module pgseq_top_tb_top;

  localparam int unsigned S = 8;
  localparam int unsigned P = 4;
  localparam int unsigned E = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pin = 1'b1;
  logic fc = 1'b0, fb = 1'b0;
  logic tsel = 1'b0, tpick = 1'b0;
  logic lock;
  logic [1:0] cpu_rate;
  logic rate_valid, osc_en, pll_en, clk_out_en, out_hiz, out_refdiv;
  logic [3:0] lock_pipe;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  // PLL model: lock follows the enable after four edges
  always @(posedge clk) begin
    if (rst) lock_pipe <= 4'd0;
    else     lock_pipe <= {lock_pipe[2:0], pll_en};
  end
  assign lock = lock_pipe[3];

  pgseq_top #(
    .SYNC_STAGES(2),
    .OSC_SETTLE (S),
    .PARK_CYCLES(P),
    .EN_DELAY   (E)
  ) dut_i (
    .clk(clk), .rst(rst), .pg_pd_pin(pin), .fsel_c(fc), .fsel_b(fb),
    .test_entry(tsel), .test_pick(tpick), .pll_lock(lock),
    .cpu_rate(cpu_rate), .rate_valid(rate_valid), .osc_en(osc_en),
    .pll_en(pll_en), .clk_out_en(clk_out_en), .out_hiz(out_hiz),
    .out_refdiv(out_refdiv)
  );

  // {fsel_c, fsel_b, expected rate code}
  localparam logic [3:0] VEC [4] = '{4'b10_00, 4'b00_01, 4'b01_10, 4'b11_11};

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_out(output int cyc);
    cyc = 0;
    while (!clk_out_en && cyc < 400) begin
      tick();
      cyc++;
    end
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    int cyc;
    logic [1:0] held;

    // R10 reset state
    tick(3);
    rst = 1'b0;
    chk("R10 osc_en", osc_en, 1);
    chk("R10 pll_en", pll_en, 0);
    chk("R10 out_en", clk_out_en, 0);
    chk("R10 valid", rate_valid, 0);
    chk("R10 rate", cpu_rate, 0);
    chk("R10 hiz/refdiv", {out_hiz, out_refdiv}, 0);

    // R1 R2 R3 R9 table walk
    for (int v = 0; v < 4; v++) begin
      rst = 1'b1; pin = 1'b1;
      fc = VEC[v][3]; fb = VEC[v][2];
      tick(2);
      rst = 1'b0;
      tick(40);
      chk("R9 gated before power-good", clk_out_en, 0);
      chk("R9 pll running before power-good", pll_en, 1);
      pin = 1'b0;
      tick(2);
      chk("R1 not yet valid", rate_valid, 0);
      tick(1);
      chk("R1 valid after capture", rate_valid, 1);
      chk("R2 rate decode", cpu_rate, VEC[v][1:0]);
      wait_out(cyc);
      chk("R9 outputs enabled after lock", clk_out_en, 1);
      fc = ~fc; fb = ~fb;
      tick(6);
      chk("R3 selects ignored", cpu_rate, VEC[v][1:0]);
    end
    held = cpu_rate;

    // R6 single-cycle glitch
    pin = 1'b1; tick(1); pin = 1'b0; tick(8);
    chk("R6 glitch ignored", clk_out_en, 1);
    chk("R3 glitch leaves rate", cpu_rate, held);

    // R6 R7 qualified request and shutdown order
    fc = 1'b1; fb = 1'b0;
    pin = 1'b1;
    tick(3);
    chk("R6 still running at edge 3", clk_out_en, 1);
    tick(1);
    chk("R6 gated at edge 4", clk_out_en, 0);
    chk("R7 pll on while parked", pll_en, 1);
    tick(P - 1);
    chk("R7 pll still on", pll_en, 1);
    tick(1);
    chk("R7 pll off", pll_en, 0);
    chk("R7 osc still on", osc_en, 1);
    tick(P - 1);
    chk("R7 osc before off", osc_en, 1);
    tick(1);
    chk("R7 osc off", osc_en, 0);
    tick(5);

    // R8 release and restart
    pin = 1'b0;
    tick(2);
    chk("R8 osc still off", osc_en, 0);
    tick(1);
    chk("R8 osc on", osc_en, 1);
    chk("R8 pll held off", pll_en, 0);
    tick(S - 1);
    chk("R8 pll off during settle", pll_en, 0);
    tick(1);
    chk("R8 pll on after settle", pll_en, 1);
    wait_out(cyc);
    chk("R9 outputs back", clk_out_en, 1);
    chk("R9 latency bound", (cyc <= 4 + 2 + E + 2) ? 8'd1 : 8'd0, 1);
    chk("R3 rate kept over power cycle", cpu_rate, held);

    // R5 test outputs
    tsel = 1'b1; tpick = 1'b0;
    tick(2);
    chk("R5 hiz not yet", out_hiz, 0);
    tick(1);
    chk("R5 hiz", {out_hiz, out_refdiv}, 8'b10);
    tpick = 1'b1;
    tick(3);
    chk("R5 refdiv", {out_hiz, out_refdiv}, 8'b01);

    // R4 recapture in test mode and masked request
    fc = 1'b0; fb = 1'b1;
    tick(4);
    chk("R4 recapture", cpu_rate, 2);
    pin = 1'b1;
    tick(12);
    chk("R4 request ignored", clk_out_en, 1);
    pin = 1'b0;
    tick(4);
    tsel = 1'b0; tpick = 1'b0;
    tick(4);
    chk("R5 test cleared", {out_hiz, out_refdiv}, 0);
    fc = 1'b1; fb = 1'b1;
    tick(6);
    chk("R3 frozen after test exit", cpu_rate, 2);
    chk("R6 still running", clk_out_en, 1);

    done = 1;
    report();
  end

endmodule